// File: doc/BRIEF.md
# Guarded Predicate Define Unit

This block holds the machine's predicate registers and applies predicate define operations to them. Each define names a destination predicate, a guard predicate, a define kind and a one-bit comparison outcome computed elsewhere. The unit combines that outcome with the destination's current value according to the kind, and commits the result at the clock edge. Several conditions can be folded into one predicate over successive defines, with no branch. This works because one kind ORs in the inverted outcome and another ANDs in the outcome.

Consumers look up guards through plain read ports. Each read port returns the value committed at the last clock edge. An operation whose guard reads 0 is meant to be suppressed by its consumer, and the suppression itself happens outside this unit. An initialise port loads a chosen predicate with a chosen value. It is used to prepare an OR-accumulating destination with 0, or an AND-accumulating destination with 1, before a chain of defines. Each define slot is a valid/ready input. A define is accepted only in a cycle where `def_valid` and `def_ready` are both high. `def_ready` is low in any cycle where `init_valid` is high, so initialisation has priority. A define offered in such a cycle is not taken and must be held by the sender until it is accepted.

Top module: `pred_define_unit`

## Requirements
- R1: After reset, predicate 0 reads 1 and every other predicate reads 0.
- R2: Predicate 0 always reads 1; defines and initialisations addressed to index 0 have no effect.
- R3: A read port returns the value committed at the previous clock edge; a define accepted in a cycle is not visible on a read port until after that cycle's edge.
- R4: Kind code 2'b00 (unconditional) writes the outcome into the destination when the guard is 1, and writes 0 when the guard is 0.
- R5: Kind code 2'b01 (OR of inverted outcome) with guard 1 writes old OR NOT outcome.
- R6: Kind code 2'b10 (AND of outcome) with guard 1 writes old AND outcome.
- R7: Kinds 2'b01 and 2'b10 leave the destination unchanged when the guard is 0.
- R8: Kind code 2'b11 changes nothing, and a slot with `def_valid` low changes nothing.
- R9: When both slots are accepted in one cycle and target the same predicate, slot 0 is applied first and slot 1 then operates on slot 0's result. Guards are always read from the previous cycle's committed state, even when slot 0 writes the guard predicate of slot 1.
- R10: With `init_valid` high, `init_val` is committed into predicate `init_idx` at the edge, and `def_ready` is low in that cycle, so no define is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| def_valid | input | NUM_SLOTS | Per-slot define valid |
| def_ready | output | 1 | Defines accepted this cycle (low while initialising) |
| def_kind | input | 2*NUM_SLOTS | Per-slot define kind, slot s at bits [2s+1:2s] |
| def_dst | input | IW*NUM_SLOTS | Per-slot destination predicate index |
| def_guard | input | IW*NUM_SLOTS | Per-slot guard predicate index |
| def_cond | input | NUM_SLOTS | Per-slot comparison outcome |
| init_valid | input | 1 | Initialise request |
| init_idx | input | IW | Predicate to initialise |
| init_val | input | 1 | Value loaded by the initialise request |
| rd_idx | input | IW*NUM_READS | Per-port read index |
| rd_val | output | NUM_READS | Per-port predicate value |

## Verification
Two things can fall in one cycle: both define slots hitting the same destination, and an initialisation competing with a pending define. The bench sweeps every pair of kinds and outcomes in both slots, aimed at one destination, against every starting value. It compares the committed result with the two update rules applied in slot order. It also has slot 0 rewrite the guard of slot 1 in the same cycle, and expects slot 1 to see the old guard. Separately, it offers a define together with an initialise request, checks that `def_ready` drops, and confirms that the define's destination keeps its value.

// File: rtl/pdu_pkg.sv
`timescale 1ns/1ps
package pdu_pkg;

  typedef enum logic [1:0] {
    DEF_UNCOND = 2'b00,
    DEF_OR_NEG = 2'b01,
    DEF_AND    = 2'b10,
    DEF_NOP    = 2'b11
  } def_kind_e;

  // New value of a destination predicate for one define operation.
  function automatic logic pdu_apply(def_kind_e kind, logic guard, logic cond, logic old);
    logic res;
    res = old;
    unique case (kind)
      DEF_UNCOND: res = guard & cond;
      DEF_OR_NEG: res = guard ? (old | ~cond) : old;
      DEF_AND:    res = guard ? (old & cond) : old;
      default:    res = old;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pdu_lookup.sv
`timescale 1ns/1ps
module pdu_lookup #(
  parameter int NUM_PREDS = 64,
  parameter int NUM_PORTS = 2,
  localparam int IW = $clog2(NUM_PREDS)
) (
  input  logic [NUM_PREDS-1:0]      pred_vec,
  input  logic [IW*NUM_PORTS-1:0]   idx,
  output logic [NUM_PORTS-1:0]      val
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [IW-1:0] sel;
    assign sel    = idx[p*IW +: IW];
    assign val[p] = pred_vec[sel];
  end
endmodule

// File: rtl/pdu_slot_update.sv
`timescale 1ns/1ps
module pdu_slot_update
  import pdu_pkg::*;
#(
  parameter int NUM_PREDS = 64,
  localparam int IW = $clog2(NUM_PREDS)
) (
  input  logic [NUM_PREDS-1:0] pred_in,
  input  logic                 take,
  input  logic [1:0]           kind,
  input  logic [IW-1:0]        dst,
  input  logic                 guard_val,
  input  logic                 cond,
  output logic [NUM_PREDS-1:0] pred_out
);
  def_kind_e kind_e;
  logic      wr_en;
  logic      new_val;

  assign kind_e  = def_kind_e'(kind);
  assign wr_en   = take && (kind_e != DEF_NOP) && (dst != '0);
  assign new_val = pdu_apply(kind_e, guard_val, cond, pred_in[dst]);

  always_comb begin
    pred_out = pred_in;
    if (wr_en) pred_out[dst] = new_val;
  end
endmodule

// File: rtl/pdu_pred_state.sv
`timescale 1ns/1ps
module pdu_pred_state #(
  parameter int NUM_PREDS = 64,
  localparam int IW = $clog2(NUM_PREDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PREDS-1:0] next_state,
  input  logic                 init_valid,
  input  logic [IW-1:0]        init_idx,
  input  logic                 init_val,
  output logic [NUM_PREDS-1:0] state_q
);
  localparam logic [NUM_PREDS-1:0] RESET_VEC = {{(NUM_PREDS-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_VEC;
    end else if (init_valid) begin
      if (init_idx != '0) state_q[init_idx] <= init_val;
    end else begin
      state_q <= {next_state[NUM_PREDS-1:1], 1'b1};
    end
  end
endmodule

// File: rtl/pred_define_unit.sv
`timescale 1ns/1ps
module pred_define_unit #(
  parameter int NUM_PREDS = 64,
  parameter int NUM_SLOTS = 2,
  parameter int NUM_READS = 2,
  localparam int IW = $clog2(NUM_PREDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SLOTS-1:0]      def_valid,
  output logic                      def_ready,
  input  logic [2*NUM_SLOTS-1:0]    def_kind,
  input  logic [IW*NUM_SLOTS-1:0]   def_dst,
  input  logic [IW*NUM_SLOTS-1:0]   def_guard,
  input  logic [NUM_SLOTS-1:0]      def_cond,
  input  logic                      init_valid,
  input  logic [IW-1:0]             init_idx,
  input  logic                      init_val,
  input  logic [IW*NUM_READS-1:0]   rd_idx,
  output logic [NUM_READS-1:0]      rd_val
);
  logic [NUM_PREDS-1:0] state_q;
  logic [NUM_SLOTS-1:0] guard_val;
  logic [NUM_PREDS-1:0] chain [NUM_SLOTS+1];

  assign def_ready = ~init_valid;
  assign chain[0]  = state_q;

  // Guards come from committed state only.
  pdu_lookup #(.NUM_PREDS(NUM_PREDS), .NUM_PORTS(NUM_SLOTS)) u_guard (
    .pred_vec (state_q),
    .idx      (def_guard),
    .val      (guard_val)
  );

  // Slots apply in issue order; each sees the result of lower slots.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    pdu_slot_update #(.NUM_PREDS(NUM_PREDS)) u_upd (
      .pred_in   (chain[s]),
      .take      (def_valid[s] & def_ready),
      .kind      (def_kind[2*s +: 2]),
      .dst       (def_dst[s*IW +: IW]),
      .guard_val (guard_val[s]),
      .cond      (def_cond[s]),
      .pred_out  (chain[s+1])
    );
  end

  pdu_pred_state #(.NUM_PREDS(NUM_PREDS)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_state (chain[NUM_SLOTS]),
    .init_valid (init_valid),
    .init_idx   (init_idx),
    .init_val   (init_val),
    .state_q    (state_q)
  );

  pdu_lookup #(.NUM_PREDS(NUM_PREDS), .NUM_PORTS(NUM_READS)) u_read (
    .pred_vec (state_q),
    .idx      (rd_idx),
    .val      (rd_val)
  );
endmodule

// File: rtl/pdu_checker.sv
`timescale 1ns/1ps
module pdu_checker #(
  parameter int NUM_PREDS = 64,
  parameter int NUM_SLOTS = 2,
  parameter int NUM_READS = 2,
  localparam int IW = $clog2(NUM_PREDS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SLOTS-1:0]      def_valid,
  input logic                      def_ready,
  input logic [2*NUM_SLOTS-1:0]    def_kind,
  input logic [IW*NUM_SLOTS-1:0]   def_dst,
  input logic [IW*NUM_SLOTS-1:0]   def_guard,
  input logic                      init_valid,
  input logic [IW-1:0]             init_idx,
  input logic                      init_val,
  input logic [IW*NUM_READS-1:0]   rd_idx,
  input logic [NUM_READS-1:0]      rd_val,
  input logic [NUM_PREDS-1:0]      state_q
);
  logic [IW-1:0] dst0;
  logic [IW-1:0] grd0;
  logic [1:0]    kind0;
  logic          shared0;
  logic          solo0;

  assign dst0  = def_dst[IW-1:0];
  assign grd0  = def_guard[IW-1:0];
  assign kind0 = def_kind[1:0];

  always_comb begin
    shared0 = 1'b0;
    for (int s = 1; s < NUM_SLOTS; s++)
      if (def_valid[s] && def_dst[s*IW +: IW] == dst0) shared0 = 1'b1;
  end

  assign solo0 = def_valid[0] && def_ready && dst0 != '0 && !shared0;

  // R2
  p_zero_reads_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx[IW-1:0] == '0) |-> rd_val[0]);

  // R4
  p_uncond_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (solo0 && kind0 == 2'b00 && !state_q[grd0]) |=> !state_q[$past(dst0)]);

  // R7
  p_accum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (solo0 && (kind0 == 2'b01 || kind0 == 2'b10) && !state_q[grd0])
      |=> state_q[$past(dst0)] == $past(state_q[dst0]));

  // R8
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_valid && def_valid == '0) |=> $stable(state_q));

  // R10
  p_init_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid && init_idx != '0) |=> state_q[$past(init_idx)] == $past(init_val));

  // R10
  p_init_blocks_def_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid && def_valid[0] && dst0 != init_idx)
      |=> state_q[$past(dst0)] == $past(state_q[dst0]));
endmodule

bind pred_define_unit pdu_checker #(
  .NUM_PREDS(NUM_PREDS), .NUM_SLOTS(NUM_SLOTS), .NUM_READS(NUM_READS)
) u_pdu_checker (
  .clk(clk), .rst_n(rst_n), .def_valid(def_valid), .def_ready(def_ready),
  .def_kind(def_kind), .def_dst(def_dst), .def_guard(def_guard),
  .init_valid(init_valid), .init_idx(init_idx), .init_val(init_val),
  .rd_idx(rd_idx), .rd_val(rd_val), .state_q(state_q)
);

// File: tb/pred_define_unit_bench.sv
`timescale 1ns/1ps
module pred_define_unit_bench;
  localparam int NP = 64;
  localparam int NS = 2;
  localparam int NR = 2;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    def_valid = '0;
  logic             def_ready;
  logic [2*NS-1:0]  def_kind = '0;
  logic [IW*NS-1:0] def_dst = '0;
  logic [IW*NS-1:0] def_guard = '0;
  logic [NS-1:0]    def_cond = '0;
  logic             init_valid = 1'b0;
  logic [IW-1:0]    init_idx = '0;
  logic             init_val = 1'b0;
  logic [IW*NR-1:0] rd_idx = '0;
  logic [NR-1:0]    rd_val;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pred_define_unit #(.NUM_PREDS(NP), .NUM_SLOTS(NS), .NUM_READS(NR)) u_pred_define_unit (
    .clk(clk), .rst_n(rst_n), .def_valid(def_valid), .def_ready(def_ready),
    .def_kind(def_kind), .def_dst(def_dst), .def_guard(def_guard), .def_cond(def_cond),
    .init_valid(init_valid), .init_idx(init_idx), .init_val(init_val),
    .rd_idx(rd_idx), .rd_val(rd_val)
  );

  // Expected rule, from the requirements.
  function automatic bit model(int kind, bit g, bit c, bit old);
    if (kind == 0) return g ? c : 1'b0;
    if (kind == 1) return g ? (old | !c) : old;
    if (kind == 2) return g ? (old & c) : old;
    return old;
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic do_init(int idx, bit v);
    @(negedge clk);
    init_valid = 1'b1; init_idx = IW'(idx); init_val = v;
    @(negedge clk);
    init_valid = 1'b0;
  endtask

  task automatic read0(int idx);
    rd_idx[IW-1:0] = IW'(idx);
    #1;
  endtask

  initial begin
    #500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents
    for (int i = 0; i < NP; i++) begin
      read0(i);
      check(rd_val[0], (i == 0), "R1", $sformatf("pred %0d after reset", i));
    end

    // Single-slot sweep: kind x guard x outcome x old value (R3..R8)
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 2; g++)
        for (int c = 0; c < 2; c++)
          for (int o = 0; o < 2; o++) begin
            string tag;
            bit exp;
            do_init(10, o[0]);
            do_init(5, g[0]);
            @(negedge clk);
            def_valid = 2'b01; def_kind[1:0] = 2'(k);
            def_dst[IW-1:0] = 6'd10; def_guard[IW-1:0] = 6'd5; def_cond[0] = c[0];
            read0(10);
            check(rd_val[0], o[0], "R3", "no bypass during define cycle");
            @(negedge clk);
            def_valid = '0;
            read0(10);
            exp = model(k, g[0], c[0], o[0]);
            if (k == 0) tag = "R4";
            else if (k == 3) tag = "R8";
            else if (g == 0) tag = "R7";
            else tag = (k == 1) ? "R5" : "R6";
            check(rd_val[0], exp, tag, $sformatf("kind %0d g %0d c %0d old %0d", k, g, c, o));
          end

    // R8: fields present but valid low
    do_init(12, 1'b1);
    @(negedge clk);
    def_valid = '0; def_kind[1:0] = 2'b00; def_dst[IW-1:0] = 6'd12;
    def_guard[IW-1:0] = 6'd0; def_cond[0] = 1'b0;
    @(negedge clk);
    read0(12);
    check(rd_val[0], 1'b1, "R8", "invalid slot writes nothing");

    // R9: both slots, same destination, all kind/outcome pairs
    for (int k0 = 0; k0 < 4; k0++)
      for (int k1 = 0; k1 < 4; k1++)
        for (int cc = 0; cc < 4; cc++)
          for (int o = 0; o < 2; o++) begin
            bit mid;
            do_init(20, o[0]);
            @(negedge clk);
            def_valid = 2'b11; def_kind = {2'(k1), 2'(k0)};
            def_dst = {6'd20, 6'd20}; def_guard = {6'd0, 6'd0};
            def_cond = 2'(cc);
            @(negedge clk);
            def_valid = '0;
            read0(20);
            mid = model(k0, 1'b1, cc[0], o[0]);
            check(rd_val[0], model(k1, 1'b1, cc[1], mid), "R9",
                  $sformatf("k0 %0d k1 %0d cond %0d old %0d", k0, k1, cc, o));
          end

    // R9: slot 0 rewrites slot 1's guard; slot 1 sees the old guard (0)
    do_init(7, 1'b0);
    do_init(8, 1'b1);
    @(negedge clk);
    def_valid = 2'b11; def_kind = {2'b00, 2'b00};
    def_dst = {6'd8, 6'd7}; def_guard = {6'd7, 6'd0}; def_cond = 2'b11;
    @(negedge clk);
    def_valid = '0;
    read0(7);
    check(rd_val[0], 1'b1, "R9", "slot 0 wrote guard pred");
    read0(8);
    check(rd_val[0], 1'b0, "R9", "slot 1 used committed guard");

    // R10: init competes with a define
    do_init(30, 1'b0);
    @(negedge clk);
    init_valid = 1'b1; init_idx = 6'd31; init_val = 1'b1;
    def_valid = 2'b01; def_kind[1:0] = 2'b00; def_dst[IW-1:0] = 6'd30;
    def_guard[IW-1:0] = 6'd0; def_cond[0] = 1'b1;
    #1;
    check(def_ready, 1'b0, "R10", "ready low during init");
    @(negedge clk);
    init_valid = 1'b0; def_valid = '0;
    read0(30);
    check(rd_val[0], 1'b0, "R10", "define not taken during init");
    read0(31);
    check(rd_val[0], 1'b1, "R10", "init value committed");
    check(def_ready, 1'b1, "R10", "ready back after init");

    // R2: index 0 ignores init and define
    do_init(0, 1'b0);
    read0(0);
    check(rd_val[0], 1'b1, "R2", "pred 0 after init to 0");
    @(negedge clk);
    def_valid = 2'b01; def_kind[1:0] = 2'b00; def_dst[IW-1:0] = 6'd0;
    def_guard[IW-1:0] = 6'd0; def_cond[0] = 1'b0;
    @(negedge clk);
    def_valid = '0;
    read0(0);
    check(rd_val[0], 1'b1, "R2", "pred 0 after define of 0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule